// File: doc/BRIEF.md
# SPI Slave Byte-Array Front End

This block lets an SPI master read and write a small on-chip array of 64 bytes. The serial pins are sampled in the system clock domain. Each transaction opens with a command byte: a direction flag, then an address. Data bytes follow, one after another, until the chip select is released. Writes go into the array. Reads are shifted back out on a serial output pin that is driven only while read data is valid.

The master may idle its clock low or high. Input bits are taken on rising serial-clock edges and output bits change on falling edges, so the block needs no setting for either clock polarity. After reset the block ignores the bus until it sees the chip select fall. Releasing the chip select part way through a byte drops that byte and returns the block to the command phase.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset the block stays locked: serial traffic does nothing until `cs_n` has gone from high to low at least once. A write sent while `cs_n` was already low at reset release leaves the array unchanged.
- R2: While `cs_n` is high, `sdo_oe` is 0 (so `sdo` is high impedance) and clock and data activity writes nothing.
- R3: Bits travel MSB first and are sampled on rising `sclk` edges. In the command byte, bit 7 is the direction (1 = write, 0 = read), bits 5..0 are the address, and bit 6 is ignored.
- R4: Each complete write data byte is stored at the current address. The address then advances, wrapping from 63 to 0.
- R5: During a read, `sdo_oe` stays 0 for the whole command byte. It rises after the falling `sclk` edge that follows the eighth command bit, with the MSB of the first data byte on `sdo`.
- R6: Read bursts return consecutive locations from the commanded address, changing `sdo` only after falling edges, and wrap from 63 to 0.
- R7: Transactions work the same with an idle-low clock (mode 0) and an idle-high clock (mode 3), with no configuration.
- R8: If `cs_n` rises in the middle of a byte, the partial byte is discarded. The next transaction starts with a fresh command byte.
- R9: Reset clears every array location to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the master |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial read data, high impedance when not enabled |
| sdo_oe | output | 1 | High while the block drives `sdo` |

## Verification
Each serial pin passes through two synchronizer stages and an edge-detect register before the sequencer acts on it. The array holds a byte three to four system cycles after the rising edge that completes it. `sdo` settles four cycles after a falling edge, and `sdo_oe` drops within four cycles of `cs_n` rising. The bench holds every serial half period for eight system cycles. It reads `sdo` and `sdo_oe` at the end of the low half, just before it raises `sclk`, and checks the enable eight cycles after releasing chip select. Written bytes are checked by reading them back over the serial interface against a model array kept in the bench.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_rf_mem.sv
module spi_rf_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic cell_en;
    assign cell_en = we && (waddr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (cell_en) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

  // R4: a write strobe leaves its byte in the addressed cell
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/spi_rf_seq.sv
module spi_rf_seq
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo_bit,
  output logic              sdo_oe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              cs_d, sclk_d;
  logic              armed, armed_n;
  phase_e            phase, phase_n;
  logic [CNT_W-1:0]  bitcnt, bitcnt_n;
  logic [DATA_W-2:0] in_sr, in_sr_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic              load_pend, load_pend_n;
  logic [DATA_W-1:0] out_sr, out_sr_n;
  logic              oe_q, oe_n;
  logic              we_q, we_n;
  logic [ADDR_W-1:0] waddr_q, waddr_n;
  logic [DATA_W-1:0] wdata_q, wdata_n;

  logic              sclk_rise, sclk_fall, cs_fall, active, byte_done;
  logic [DATA_W-1:0] byte_in;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = cs_d & ~cs_s;
  assign active    = armed & ~cs_s;
  assign byte_in   = {in_sr, sdi_s};
  assign byte_done = (bitcnt == LAST_BIT);

  always_comb begin
    armed_n     = armed;
    phase_n     = phase;
    bitcnt_n    = bitcnt;
    in_sr_n     = in_sr;
    addr_n      = addr;
    load_pend_n = load_pend;
    out_sr_n    = out_sr;
    oe_n        = oe_q;
    we_n        = 1'b0;
    waddr_n     = waddr_q;
    wdata_n     = wdata_q;

    if (cs_fall) armed_n = 1'b1;

    if (cs_s) begin
      bitcnt_n    = '0;
      phase_n     = PH_CMD;
      load_pend_n = 1'b0;
      oe_n        = 1'b0;
    end else if (active) begin
      if (sclk_rise) begin
        in_sr_n  = byte_in[DATA_W-2:0];
        bitcnt_n = byte_done ? '0 : bitcnt + 1'b1;
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              addr_n      = byte_in[ADDR_W-1:0];
              phase_n     = byte_in[DATA_W-1] ? PH_WRITE : PH_READ;
              load_pend_n = ~byte_in[DATA_W-1];
            end
            PH_WRITE: begin
              we_n    = 1'b1;
              waddr_n = addr;
              wdata_n = byte_in;
              addr_n  = addr + 1'b1;
            end
            PH_READ: begin
              load_pend_n = 1'b1;
            end
            default: phase_n = PH_CMD;
          endcase
        end
      end else if (sclk_fall && (phase == PH_READ)) begin
        if (load_pend) begin
          out_sr_n    = rdata;
          addr_n      = addr + 1'b1;
          oe_n        = 1'b1;
          load_pend_n = 1'b0;
        end else begin
          out_sr_n = {out_sr[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d      <= 1'b0;
      sclk_d    <= 1'b0;
      armed     <= 1'b0;
      phase     <= PH_CMD;
      bitcnt    <= '0;
      in_sr     <= '0;
      addr      <= '0;
      load_pend <= 1'b0;
      out_sr    <= '0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      cs_d      <= cs_s;
      sclk_d    <= sclk_s;
      armed     <= armed_n;
      phase     <= phase_n;
      bitcnt    <= bitcnt_n;
      in_sr     <= in_sr_n;
      addr      <= addr_n;
      load_pend <= load_pend_n;
      out_sr    <= out_sr_n;
      oe_q      <= oe_n;
      we_q      <= we_n;
      waddr_q   <= waddr_n;
      wdata_q   <= wdata_n;
    end
  end

  assign we      = we_q;
  assign waddr   = waddr_q;
  assign wdata   = wdata_q;
  assign raddr   = addr;
  assign sdo_bit = out_sr[DATA_W-1];
  assign sdo_oe  = oe_q;

  // R2: a deselected bus never leaves the output driven
  a_r2_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  // R1: nothing reaches the array before the first chip-select fall
  a_r1_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !we);

  // R5: the output is only driven in the read data phase
  a_r5_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> phase == PH_READ);

  // R8: deselect returns the bit position to the start of a byte
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> bitcnt == '0);

  // R4: the address has moved one past the location being written
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> addr == ADDR_W'(waddr + 1'b1));

endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);

  localparam int PIN_W = 3;

  logic [1:0]        rst_pipe;
  logic              rst_n_i;
  logic [PIN_W-1:0]  pins_s;
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              sdo_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  // chip select resets as "low" so only a real high-to-low edge unlocks
  spi_rf_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_i),
    .d    ({cs_n, sclk, sdi}),
    .q    (pins_s)
  );

  spi_rf_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .cs_s   (pins_s[2]),
    .sclk_s (pins_s[1]),
    .sdi_s  (pins_s[0]),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .raddr  (raddr),
    .rdata  (rdata),
    .sdo_bit(sdo_bit),
    .sdo_oe (sdo_oe)
  );

  spi_rf_mem #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_mem (
    .clk  (clk),
    .rst_n(rst_n_i),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(raddr),
    .rdata(rdata)
  );

  assign sdo = sdo_oe ? sdo_bit : 1'bz;

endmodule

// File: tb/spi_regfile_slave_bench.sv
module spi_regfile_slave_bench;

  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  wire  sdo;
  logic sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [7:0] model [64];

  always #5 clk = ~clk;

  spi_regfile_slave u_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'(a * 37 + salt * 91 + 5);
  endfunction

  task automatic send_bits(input logic [7:0] tx, input int n,
                           output logic [7:0] rx, output logic all_oe, output logic any_oe);
    rx = '0; all_oe = 1'b1; any_oe = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b0;
      sdi  = tx[i];
      wait_clk(HP);
      rx[i]  = sdo;
      all_oe = all_oe & sdo_oe;
      any_oe = any_oe | sdo_oe;
      sclk = 1'b1;
      wait_clk(HP);
    end
  endtask

  task automatic begin_txn(input bit mode3);
    sclk = mode3;
    wait_clk(HP);
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic end_txn(input bit mode3);
    if (!mode3) begin
      sclk = 1'b0;
      wait_clk(HP);
    end
    cs_n = 1'b1;
    wait_clk(HP);
    chk("R2 oe after deselect", {7'd0, sdo_oe}, 8'd0);
    wait_clk(HP);
  endtask

  task automatic wr_burst(input bit mode3, input int start, input int n, input int salt);
    logic [7:0] rx;
    logic a, b;
    begin_txn(mode3);
    send_bits(8'h80 | 8'(start), 8, rx, a, b);
    for (int k = 0; k < n; k++) begin
      send_bits(pat((start + k) % 64, salt), 8, rx, a, b);
      model[(start + k) % 64] = pat((start + k) % 64, salt);
    end
    end_txn(mode3);
  endtask

  task automatic rd_burst(input bit mode3, input logic [7:0] cmd, input int n, input string req);
    logic [7:0] rx;
    logic all_oe, any_oe;
    int start;
    start = int'(cmd[5:0]);
    begin_txn(mode3);
    send_bits(cmd, 8, rx, all_oe, any_oe);
    chk("R5 oe low in command byte", {7'd0, any_oe}, 8'd0);
    for (int k = 0; k < n; k++) begin
      send_bits(8'h00, 8, rx, all_oe, any_oe);
      chk({req, " oe during data"}, {7'd0, all_oe}, 8'd1);
      chk(req, rx, model[(start + k) % 64]);
    end
    end_txn(mode3);
  endtask

  initial begin
    logic [7:0] rx;
    logic a, b;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wait_clk(10);
    chk("R2 reset oe", {7'd0, sdo_oe}, 8'd0);
    rst_n = 1'b1;
    wait_clk(10);

    // R1: chip select low since reset, no fall seen: write must be ignored
    send_bits(8'h85, 8, rx, a, b);
    send_bits(8'hAA, 8, rx, a, b);
    chk("R1 no output while locked", {7'd0, b}, 8'd0);
    sclk = 1'b0; wait_clk(HP);
    cs_n = 1'b1; wait_clk(2 * HP);
    rd_burst(1'b0, 8'h05, 1, "R1 locked write ignored");
    rd_burst(1'b1, 8'h00, 64, "R9 reset contents zero");

    // R4 R7: full-array write burst in mode 0, read back in mode 3 (R6 R3)
    wr_burst(1'b0, 0, 64, 1);
    rd_burst(1'b1, 8'h00, 64, "R6 R7 mode3 burst read");
    // R7: the other way round
    wr_burst(1'b1, 0, 64, 2);
    rd_burst(1'b0, 8'h00, 64, "R7 mode0 burst read");

    // R4 R6: wrap from 63 to 0 on both directions
    wr_burst(1'b0, 62, 4, 3);
    rd_burst(1'b0, 8'h3F, 3, "R6 read wrap");
    rd_burst(1'b1, 8'h3E, 4, "R4 write wrap");

    // R3: bit 6 of the command is ignored
    begin_txn(1'b0);
    send_bits(8'hC0 | 8'd10, 8, rx, a, b);
    send_bits(8'h3C, 8, rx, a, b);
    model[10] = 8'h3C;
    end_txn(1'b0);
    rd_burst(1'b1, 8'h40 | 8'd10, 1, "R3 bit6 ignored");

    // R2: activity while deselected writes nothing and never drives sdo
    cs_n = 1'b1;
    send_bits(8'h83, 8, rx, a, b);
    chk("R2 oe while deselected", {7'd0, b}, 8'd0);
    send_bits(8'h5A, 8, rx, a, b);
    chk("R2 oe while deselected", {7'd0, b}, 8'd0);
    sclk = 1'b0; wait_clk(2 * HP);
    rd_burst(1'b0, 8'h03, 1, "R2 deselected write ignored");

    // R8: partial data byte dropped
    begin_txn(1'b0);
    send_bits(8'h80 | 8'd20, 8, rx, a, b);
    send_bits(8'h11, 8, rx, a, b);
    model[20] = 8'h11;
    send_bits(8'hFF, 5, rx, a, b);
    end_txn(1'b0);
    rd_burst(1'b0, 8'd20, 2, "R8 partial data byte dropped");

    // R8: partial command dropped, next command framed from bit 0
    begin_txn(1'b1);
    send_bits(8'h80, 4, rx, a, b);
    end_txn(1'b1);
    rd_burst(1'b1, 8'd21, 1, "R8 partial command dropped");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule